// File: doc/BRIEF.md
# Pulse Frequency Band Router

This block sorts an incoming digital pulse train into one of three frequency bands and steers the pulses to a matching output. It measures the spacing between successive rising edges with two retriggerable one-shot timers, each built from a down-counter running on the system clock. One timer has a long interval and the other a short one. Each rising edge restarts both timers. Just before the restart, the block records which timers were still running. That record shows whether the gap since the previous edge was shorter than each interval.

The recorded pair selects one band: low (gap at or above the long interval), mid (gap at or above the short interval but below the long one) or high (gap below the short interval). The synchronized input is gated onto the output of the selected band only. The band flags show the last decision, so downstream logic can use them as a steady indication of the input rate. The interval inputs are counts of clock cycles and must satisfy long > short > 0.

Top module: `pulse_band_router`

## Requirements
- R1: While `rst` is high at a clock edge, all timers and decision registers clear. After that edge `band_low`=1, `band_mid`=0, `band_high`=0, and all three pass outputs are 0.
- R2: `pulse_in` passes through a two-stage synchronizer, so the pass outputs follow `pulse_in` two clock edges later. A rising edge of the synchronized level is a trigger that lasts exactly one cycle.
- R3: The first trigger after reset is classified as low band, because no earlier edge exists.
- R4: The period is the number of clock cycles between two successive triggers. A period below `ivl_short` is classified as high band (`band_high`=1).
- R5: A period of at least `ivl_short` and below `ivl_long` is classified as mid band (`band_mid`=1).
- R6: A period of at least `ivl_long` is classified as low band. A period exactly equal to an interval does not count as shorter than it.
- R7: Exactly one of `band_low`, `band_mid` and `band_high` is high in every cycle.
- R8: Each pass output equals the synchronized input ANDed with its band. In a trigger cycle the new classification is used; in every other cycle the held band is used. At most one pass output is high.
- R9: The band flags take the new classification on the clock edge that ends a trigger cycle, and they hold it until the next trigger.
- R10: Each timer copies its interval input at a trigger. A change of `ivl_long` or `ivl_short` between triggers first affects the classification of the period that starts at the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous pulse train to classify |
| ivl_long | input | CNT_W | Long interval in clock cycles (upper edge of the mid band) |
| ivl_short | input | CNT_W | Short interval in clock cycles (lower edge of the mid band) |
| pass_low | output | 1 | Synchronized input gated by the low band |
| pass_mid | output | 1 | Synchronized input gated by the mid band |
| pass_high | output | 1 | Synchronized input gated by the high band |
| band_low | output | 1 | Held decision: last period at or above the long interval |
| band_mid | output | 1 | Held decision: last period between the two intervals |
| band_high | output | 1 | Held decision: last period below the short interval |

## Verification
The assertions assume that `ivl_long` is always greater than `ivl_short` and that `ivl_short` is nonzero. Under that assumption, a running short timer implies a running long timer, and exactly one band is selected. The stimulus only uses interval pairs that satisfy this rule, including when it changes the intervals in the middle of a pulse train. Every period it generates is at least two cycles, which is the shortest gap the synchronizer can produce between two rising edges.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int NUM_BANDS  = 3;
  localparam int NUM_TIMERS = 2;
  localparam int TMR_LONG   = 0;
  localparam int TMR_SHORT  = 1;

  // One-hot band code: bit 0 low, bit 1 mid, bit 2 high.
  typedef logic [NUM_BANDS-1:0] band_vec_t;

  localparam band_vec_t BAND_LOW  = 3'b001;
  localparam band_vec_t BAND_MID  = 3'b010;
  localparam band_vec_t BAND_HIGH = 3'b100;

  // Maps the "still running" state of both timers to a band.
  function automatic band_vec_t band_select(input logic long_on, input logic short_on);
    if (short_on)     return BAND_HIGH;
    else if (long_on) return BAND_MID;
    else              return BAND_LOW;
  endfunction

  // Gates the synchronized level onto the chosen band.
  function automatic band_vec_t band_gate(input logic level, input band_vec_t band);
    return level ? band : '0;
  endfunction
endpackage

// File: rtl/pbr_sync_edge.sv
module pbr_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               prev_level;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-2:0], din};
  end

  assign level      = chain_q[SYNC_STAGES-1];
  assign prev_level = chain_q[SYNC_STAGES];
  assign rise       = level & ~prev_level;

  // R2: a trigger never lasts longer than one cycle
  a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/pbr_oneshot.sv
module pbr_oneshot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [CNT_W-1:0] ivl,
  output logic             active
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  // Load interval-1 so that a gap exactly equal to the interval sees zero.
  function automatic logic [CNT_W-1:0] reload_count(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] decay(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  always_comb begin
    if (trig) cnt_next = reload_count(ivl);
    else      cnt_next = decay(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

  assign active = (cnt_q != '0);

  // R10: the interval present at a trigger sets the count
  a_r10_reload: assert property (@(posedge clk) disable iff (rst)
    (trig && ivl != '0) |=> cnt_q == $past(ivl) - CNT_W'(1));
  // R4: between triggers the count drops by one per cycle
  a_r4_decay: assert property (@(posedge clk) disable iff (rst)
    (!trig && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R6: an expired timer stays expired until retriggered
  a_r6_floor: assert property (@(posedge clk) disable iff (rst)
    (!trig && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/pulse_band_router.sv
module pulse_band_router #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] ivl_long,
  input  logic [CNT_W-1:0] ivl_short,
  output logic             pass_low,
  output logic             pass_mid,
  output logic             pass_high,
  output logic             band_low,
  output logic             band_mid,
  output logic             band_high
);
  import pbr_pkg::*;

  logic                  in_level;
  logic                  in_rise;
  logic [NUM_TIMERS-1:0] tmr_active;
  logic [NUM_TIMERS-1:0] seen_q;
  logic [CNT_W-1:0]      ivl_arr [NUM_TIMERS];
  band_vec_t             band_held;
  band_vec_t             band_fresh;
  band_vec_t             band_now;
  band_vec_t             pass_vec;

  pbr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (pulse_in),
    .level (in_level),
    .rise  (in_rise)
  );

  assign ivl_arr[TMR_LONG]  = ivl_long;
  assign ivl_arr[TMR_SHORT] = ivl_short;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    pbr_oneshot #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .trig   (in_rise),
      .ivl    (ivl_arr[t]),
      .active (tmr_active[t])
    );
  end

  // Capture the timer state on the same edge that reloads the counters.
  always_ff @(posedge clk) begin
    if (rst)          seen_q <= '0;
    else if (in_rise) seen_q <= tmr_active;
  end

  assign band_held  = band_select(seen_q[TMR_LONG], seen_q[TMR_SHORT]);
  assign band_fresh = band_select(tmr_active[TMR_LONG], tmr_active[TMR_SHORT]);
  assign band_now   = in_rise ? band_fresh : band_held;
  assign pass_vec   = band_gate(in_level, band_now);

  assign band_low  = band_held[0];
  assign band_mid  = band_held[1];
  assign band_high = band_held[2];
  assign pass_low  = pass_vec[0];
  assign pass_mid  = pass_vec[1];
  assign pass_high = pass_vec[2];

  // R7: one band at a time
  a_r7_one_band: assert property (@(posedge clk) disable iff (rst)
    $countones({band_high, band_mid, band_low}) == 1);
  // R8: pulses go to one output at most
  a_r8_pass_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass_high, pass_mid, pass_low}));
  // R4: the short timer cannot outlive the long one (needs ivl_long > ivl_short)
  a_r4_nested: assert property (@(posedge clk) disable iff (rst)
    tmr_active[TMR_SHORT] |-> tmr_active[TMR_LONG]);
  // R9: the decision holds between triggers
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_rise |=> $stable({band_high, band_mid, band_low}));
endmodule

// File: tb/pulse_band_router_test.sv
module pulse_band_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic [W-1:0] ivl_long = 8'd20;
  logic [W-1:0] ivl_short = 8'd8;
  logic pass_low, pass_mid, pass_high, band_low, band_mid, band_high;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_band_router #(.CNT_W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .ivl_long(ivl_long), .ivl_short(ivl_short),
    .pass_low(pass_low), .pass_mid(pass_mid), .pass_high(pass_high),
    .band_low(band_low), .band_mid(band_mid), .band_high(band_high)
  );

  // Behavioural model: sampled-input history plus time of the last edge.
  bit m_h1 = 0, m_h2 = 0, m_h3 = 0;
  bit m_have = 0;
  int m_cyc = 0, m_last = 0, m_l1 = 0, m_l2 = 0;
  int m_held = 0;  // 0 low, 1 mid, 2 high

  function automatic bit m_trig();
    return m_h2 && !m_h3;
  endfunction

  function automatic int m_fresh();
    int gap;
    if (!m_have) return 0;
    gap = m_cyc - m_last;
    if (gap < m_l2) return 2;
    if (gap < m_l1) return 1;
    return 0;
  endfunction

  function automatic logic [2:0] code_vec(int b);
    return 3'(1 << b);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_h1 = 0; m_h2 = 0; m_h3 = 0; m_have = 0; m_cyc = 0; m_held = 0;
    end else begin
      if (m_trig()) begin
        m_held = m_fresh();
        m_have = 1; m_last = m_cyc;
        m_l1 = int'(ivl_long); m_l2 = int'(ivl_short);
      end
      m_cyc++;
      m_h3 = m_h2; m_h2 = m_h1; m_h1 = pulse_in;
    end
  end

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (live && !rst) begin
      check("R9 band flags", {band_high, band_mid, band_low}, code_vec(m_held));
      check("R8 pass outputs", {pass_high, pass_mid, pass_low},
            m_h2 ? code_vec(m_trig() ? m_fresh() : m_held) : 3'b000);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; pulse_in = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic train(int period, int n);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1;
      repeat (period / 2) @(negedge clk);
      pulse_in = 0;
      repeat (period - period / 2) @(negedge clk);
    end
  endtask

  // After a train, let the final edge settle and check the held band.
  task automatic expect_band(string req, logic [2:0] exp);
    pulse_in = 1;
    repeat (3) @(negedge clk);
    check(req, {band_high, band_mid, band_low}, exp);
    pulse_in = 0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 band flags after reset", {band_high, band_mid, band_low}, 3'b001);
    check("R1 pass after reset", {pass_high, pass_mid, pass_low}, 3'b000);
    rst = 0;
    live = 1;
    @(negedge clk);
    // R2 and R3: first edge, two-cycle latency, low band
    pulse_in = 1;
    @(negedge clk);
    check("R2 no pass after one edge", {pass_high, pass_mid, pass_low}, 3'b000);
    @(negedge clk);
    check("R3 first edge passes on low", {pass_high, pass_mid, pass_low}, 3'b001);
    @(negedge clk);
    check("R3 first edge held low", {band_high, band_mid, band_low}, 3'b001);
    repeat (2) @(negedge clk);
    pulse_in = 0;
    repeat (30) @(negedge clk);

    // R6: longer than and equal to the long interval -> low
    do_reset(); train(30, 3); expect_band("R6 period 30 low", 3'b001);
    do_reset(); train(20, 3); expect_band("R6 period equal long low", 3'b001);
    // R5: mid band, including equality with the short interval
    do_reset(); train(19, 3); expect_band("R5 period 19 mid", 3'b010);
    do_reset(); train(8, 4);  expect_band("R5 period equal short mid", 3'b010);
    // R4: high band
    do_reset(); train(7, 4);  expect_band("R4 period 7 high", 3'b100);
    do_reset(); train(2, 6);  expect_band("R4 period 2 high", 3'b100);
    // R7: moving through bands without reset
    do_reset(); train(4, 3); train(12, 3); train(40, 2);
    expect_band("R7 back to low", 3'b001);

    // R10: raise the long interval mid train; only later periods use it
    do_reset();
    train(25, 2);
    ivl_long = 8'd40; ivl_short = 8'd10;
    pulse_in = 1;
    repeat (12) @(negedge clk);
    pulse_in = 0;
    repeat (11) @(negedge clk);
    check("R10 old interval still applies", {band_high, band_mid, band_low}, 3'b001);
    train(25, 2);
    expect_band("R10 new interval applies", 3'b010);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule